// File: doc/BRIEF.md
# Self-Test Command Dispatcher

This block sits between a debug host and the on-chip self-test engines. The host pushes a fixed six-byte command frame over a byte-wide valid/ready input. The dispatcher reduces byte 0 to a test number and extracts the arguments that the engines need. It then either raises an interrupt request to the host, starts the register test engine, starts the memory test engine, or drops the frame. Once the selected engine reports completion, it builds a six-byte answer frame and shifts it back out over a byte-wide valid/ready output.

Only one test can be in progress at a time. Between the last command byte and the last answer byte the input stays closed. The engines share one result bus, which is sampled only on the completion strobe of the engine that was started. If the error code is zero, the answer echoes the command. If it is non-zero, the answer carries the read data, the failing address and the error code.

Top module: `stc_dispatcher`

## Requirements
- R1: After reset, and whenever no test is in progress, `in_ready` is 1 and `out_valid` is 0. Command bytes are taken on cycles where `in_valid` and `in_ready` are both 1, and the first byte taken is byte 0.
- R2: The test number is byte 0 AND 7. Values 2 and 3 give a one-cycle `reg_start` pulse, and values 4 and 5 give a one-cycle `mem_start` pulse. The pulse is visible in the cycle after the one that follows the edge accepting byte 5. The two pulses never occur together.
- R3: Test numbers 0, 6 and 7 run nothing. No start pulse, no `irq` and no answer are produced, and `in_ready` returns to 1 two cycles after byte 5 is taken.
- R4: Test number 1 starts no engine. It gives a one-cycle `irq` pulse in the same cycle that the answer becomes valid. The answer is the success shape of R6.
- R5: `test_id` is the test number and `arg_module` is byte 1. `arg_pattern` is {byte 1, byte 2} for test 3, {byte 2, byte 3} for test 5, and 0 for all other tests. All three hold steady from dispatch until the last answer byte is taken.
- R6: Success answer, used when `res_err` is 0 at completion and always for test 1: byte 0 is the test number, bytes 1 to 4 repeat command bytes 1 to 4, and byte 5 is 0.
- R7: Failure answer, used when `res_err` is non-zero at completion: byte 0 is 0, bytes 1 and 2 hold `res_rdata` high then low, bytes 3 and 4 hold `res_addr` high then low, and byte 5 holds `res_err` zero-extended. In the error code, bit 0 flags a left-byte parity error, bit 1 a right-byte parity error and bit 2 a data mismatch.
- R8: Only the `*_done` strobe of the engine that was started completes a test. A strobe from the other engine is ignored and no answer appears.
- R9: `in_ready` is 0 from the cycle after byte 5 is taken until the last answer byte is taken, and never coincides with `out_valid`. Bytes offered during that time are not taken.
- R10: Answer bytes leave in order 0 to 5. While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command byte offered |
| in_data | input | 8 | Command byte |
| in_ready | output | 1 | Dispatcher accepts a command byte |
| out_valid | output | 1 | Answer byte offered |
| out_data | output | 8 | Answer byte |
| out_ready | input | 1 | Host accepts an answer byte |
| test_id | output | 3 | Decoded test number for the engines |
| arg_module | output | 8 | Module number argument |
| arg_pattern | output | 16 | Test pattern argument |
| reg_start | output | 1 | One-cycle start to the register engine |
| reg_done | input | 1 | Register engine completion strobe |
| mem_start | output | 1 | One-cycle start to the memory engine |
| mem_done | input | 1 | Memory engine completion strobe |
| res_rdata | input | 16 | Read data reported with completion |
| res_addr | input | 16 | Failing address reported with completion |
| res_err | input | 3 | Error code reported with completion |
| irq | output | 1 | One-cycle interrupt request to the host |

## Verification
Several properties are checked on every cycle. Start and interrupt pulses last one cycle and never overlap. Input and output readiness exclude each other. The input is closed once a start has been issued. The answer byte holds under back-pressure, and the arguments stay steady while a test is in progress. The bench scenarios cover the rest: the byte-exact content of both answer shapes, the argument extraction for each test number, the dropping of undefined test numbers, the timing of the start pulse, and the rejection of a completion strobe from the engine that was not started.

// File: rtl/stc_pkg.sv
package stc_pkg;
    localparam int BYTE_W    = 8;
    localparam int FRAME_LEN = 6;
    localparam int ARG_BYTES = FRAME_LEN - 2;
    localparam int WORD_W    = 2 * BYTE_W;
    localparam int TEST_W    = 3;
    localparam int ERR_W     = 3;
    localparam int IDX_W     = $clog2(FRAME_LEN);

    typedef logic [BYTE_W-1:0]                 byte_t;
    typedef logic [FRAME_LEN-1:0][BYTE_W-1:0]  frame_t;
    typedef logic [ARG_BYTES-1:0][BYTE_W-1:0]  arg_bytes_t;

    typedef enum logic [1:0] {
        ST_CAPTURE  = 2'd0,
        ST_DISPATCH = 2'd1,
        ST_WAIT     = 2'd2,
        ST_SEND     = 2'd3
    } stc_state_e;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_IRQ  = 2'd1,
        KIND_REG  = 2'd2,
        KIND_MEM  = 2'd3
    } stc_kind_e;
endpackage

// File: rtl/stc_arg_decode.sv
module stc_arg_decode
    import stc_pkg::*;
(
    input  logic [TEST_W-1:0] test_num,
    input  byte_t             b1,
    input  byte_t             b2,
    input  byte_t             b3,
    output stc_kind_e         kind,
    output byte_t             module_no,
    output logic [WORD_W-1:0] pattern
);
    always_comb begin
        unique case (test_num)
            3'd1:       kind = KIND_IRQ;
            3'd2, 3'd3: kind = KIND_REG;
            3'd4, 3'd5: kind = KIND_MEM;
            default:    kind = KIND_NONE;
        endcase
    end

    assign module_no = b1;

    always_comb begin
        unique case (test_num)
            3'd3:    pattern = {b1, b2};
            3'd5:    pattern = {b2, b3};
            default: pattern = '0;
        endcase
    end
endmodule

// File: rtl/stc_answer_fmt.sv
module stc_answer_fmt
    import stc_pkg::*;
(
    input  logic [TEST_W-1:0] test_num,
    input  arg_bytes_t        echo,
    input  logic              use_result,
    input  logic [WORD_W-1:0] rdata,
    input  logic [WORD_W-1:0] addr,
    input  logic [ERR_W-1:0]  err,
    output frame_t            answer
);
    logic  fail;
    frame_t ok_frame;
    frame_t bad_frame;

    assign fail = use_result && (err != '0);

    assign ok_frame[0]           = {{(BYTE_W-TEST_W){1'b0}}, test_num};
    assign ok_frame[FRAME_LEN-1] = '0;

    for (genvar k = 0; k < ARG_BYTES; k++) begin : g_echo
        assign ok_frame[k+1] = echo[k];
    end

    assign bad_frame[0] = '0;
    assign bad_frame[1] = rdata[WORD_W-1:BYTE_W];
    assign bad_frame[2] = rdata[BYTE_W-1:0];
    assign bad_frame[3] = addr[WORD_W-1:BYTE_W];
    assign bad_frame[4] = addr[BYTE_W-1:0];
    assign bad_frame[5] = {{(BYTE_W-ERR_W){1'b0}}, err};

    assign answer = fail ? bad_frame : ok_frame;
endmodule

// File: rtl/stc_dispatcher.sv
module stc_dispatcher
    import stc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [7:0]        out_data,
    input  logic              out_ready,
    output logic [2:0]        test_id,
    output logic [7:0]        arg_module,
    output logic [15:0]       arg_pattern,
    output logic              reg_start,
    input  logic              reg_done,
    output logic              mem_start,
    input  logic              mem_done,
    input  logic [15:0]       res_rdata,
    input  logic [15:0]       res_addr,
    input  logic [2:0]        res_err,
    output logic              irq
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

    typedef struct packed {
        stc_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic [TEST_W-1:0] test;
        arg_bytes_t        args;
        frame_t            answer;
        logic              reg_start;
        logic              mem_start;
        logic              irq;
    } stc_regs_t;

    localparam stc_regs_t RESET_VAL = '{
        st:        ST_CAPTURE,
        idx:       '0,
        test:      '0,
        args:      '0,
        answer:    '0,
        reg_start: 1'b0,
        mem_start: 1'b0,
        irq:       1'b0
    };

    stc_regs_t         q, d;
    stc_kind_e         kind;
    logic [WORD_W-1:0] pattern;
    byte_t             module_no;
    frame_t            fmt_frame;
    logic              done_sel;

    stc_arg_decode i_decode (
        .test_num  (q.test),
        .b1        (q.args[0]),
        .b2        (q.args[1]),
        .b3        (q.args[2]),
        .kind      (kind),
        .module_no (module_no),
        .pattern   (pattern)
    );

    stc_answer_fmt i_fmt (
        .test_num   (q.test),
        .echo       (q.args),
        .use_result (q.st == ST_WAIT),
        .rdata      (res_rdata),
        .addr       (res_addr),
        .err        (res_err),
        .answer     (fmt_frame)
    );

    assign done_sel = (kind == KIND_REG) ? reg_done :
                      (kind == KIND_MEM) ? mem_done : 1'b0;

    always_comb begin
        d           = q;
        d.reg_start = 1'b0;
        d.mem_start = 1'b0;
        d.irq       = 1'b0;
        unique case (q.st)
            ST_CAPTURE: begin
                if (in_valid) begin
                    if (q.idx == '0) begin
                        d.test = in_data[TEST_W-1:0];
                    end
                    for (int k = 0; k < ARG_BYTES; k++) begin
                        if (q.idx == IDX_W'(k + 1)) begin
                            d.args[k] = in_data;
                        end
                    end
                    if (q.idx == LAST_IDX) begin
                        d.idx = '0;
                        d.st  = ST_DISPATCH;
                    end else begin
                        d.idx = q.idx + IDX_W'(1);
                    end
                end
            end
            ST_DISPATCH: begin
                unique case (kind)
                    KIND_IRQ: begin
                        d.irq    = 1'b1;
                        d.answer = fmt_frame;
                        d.st     = ST_SEND;
                    end
                    KIND_REG: begin
                        d.reg_start = 1'b1;
                        d.st        = ST_WAIT;
                    end
                    KIND_MEM: begin
                        d.mem_start = 1'b1;
                        d.st        = ST_WAIT;
                    end
                    default: d.st = ST_CAPTURE;
                endcase
            end
            ST_WAIT: begin
                if (done_sel) begin
                    d.answer = fmt_frame;
                    d.st     = ST_SEND;
                end
            end
            ST_SEND: begin
                if (out_ready) begin
                    if (q.idx == LAST_IDX) begin
                        d.idx = '0;
                        d.st  = ST_CAPTURE;
                    end else begin
                        d.idx = q.idx + IDX_W'(1);
                    end
                end
            end
            default: d = RESET_VAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RESET_VAL;
        end else begin
            q <= d;
        end
    end

    assign in_ready    = (q.st == ST_CAPTURE);
    assign out_valid   = (q.st == ST_SEND);
    assign out_data    = q.answer[q.idx];
    assign test_id     = q.test;
    assign arg_module  = module_no;
    assign arg_pattern = pattern;
    assign reg_start   = q.reg_start;
    assign mem_start   = q.mem_start;
    assign irq         = q.irq;
endmodule

// File: rtl/stc_checker.sv
module stc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [7:0]  out_data,
    input logic        reg_start,
    input logic        mem_start,
    input logic        irq,
    input logic [2:0]  test_id,
    input logic [7:0]  arg_module,
    input logic [15:0] arg_pattern
);
    // R2
    reg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_start |=> !reg_start);

    // R2
    mem_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_start |=> !mem_start);

    // R2
    single_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_start && mem_start));

    // R4
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R4
    irq_with_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> out_valid && !reg_start && !mem_start);

    // R9
    port_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R9
    closed_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_start || mem_start) |-> !in_ready && !out_valid);

    // R10
    answer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_data));

    // R5
    args_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && $past(!in_ready)) |->
            $stable(arg_pattern) && $stable(arg_module) && $stable(test_id));
endmodule

bind stc_dispatcher stc_checker i_stc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .reg_start   (reg_start),
    .mem_start   (mem_start),
    .irq         (irq),
    .test_id     (test_id),
    .arg_module  (arg_module),
    .arg_pattern (arg_pattern)
);

// File: tb/test_stc_dispatcher.sv
`timescale 1ns/1ps
module test_stc_dispatcher;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_ready = 1'b0;
    logic [2:0]  test_id;
    logic [7:0]  arg_module;
    logic [15:0] arg_pattern;
    logic        reg_start, mem_start, irq;
    logic        reg_done = 1'b0;
    logic        mem_done = 1'b0;
    logic [15:0] res_rdata = '0;
    logic [15:0] res_addr = '0;
    logic [2:0]  res_err = '0;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    stc_dispatcher i_stc_dispatcher (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .test_id(test_id), .arg_module(arg_module), .arg_pattern(arg_pattern),
        .reg_start(reg_start), .reg_done(reg_done),
        .mem_start(mem_start), .mem_done(mem_done),
        .res_rdata(res_rdata), .res_addr(res_addr), .res_err(res_err),
        .irq(irq)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_pattern(input int t, input logic [47:0] f);
        if (t == 3) return {f[15:8], f[23:16]};
        if (t == 5) return {f[23:16], f[31:24]};
        return 16'h0000;
    endfunction

    function automatic logic [47:0] exp_answer(input int t, input logic [47:0] f,
                                               input bit use_res, input logic [2:0] err,
                                               input logic [15:0] rd, input logic [15:0] ad);
        if (use_res && err != 3'd0)
            return {5'b0, err, ad[7:0], ad[15:8], rd[7:0], rd[15:8], 8'h00};
        return {8'h00, f[39:32], f[31:24], f[23:16], f[15:8], 5'b0, 3'(t)};
    endfunction

    task automatic send_byte(input logic [7:0] b);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic receive(input logic [47:0] exp);
        for (int i = 0; i < 6; i++) begin
            int stall = $urandom % 3;
            for (int s = 0; s < stall; s++) begin
                logic [7:0] held = out_data;
                out_ready = 1'b0;
                @(negedge clk);
                // R10
                check(out_valid && out_data == held, "R10", "hold under stall",
                      out_data, held);
            end
            check(in_ready == 1'b0, "R9", "input closed while answering", in_ready, 0);
            out_ready = 1'b1;
            // R6 / R7 byte content
            check(out_valid && out_data == exp[8*i +: 8], "R6/R7",
                  $sformatf("answer byte %0d", i), out_data, exp[8*i +: 8]);
            @(negedge clk);
            out_ready = 1'b0;
        end
        // R1
        check(in_ready && !out_valid, "R1", "idle after answer", {in_ready, out_valid}, 2'b10);
    endtask

    task automatic run_frame(input logic [47:0] f, input logic [2:0] err,
                             input logic [15:0] rd, input logic [15:0] ad,
                             input bit wrong_done);
        int t = int'(f[2:0]);
        for (int i = 0; i < 6; i++) begin
            repeat ($urandom % 2) @(negedge clk);
            send_byte(f[8*i +: 8]);
        end
        // R9
        check(!in_ready && !reg_start && !mem_start, "R9", "closed at dispatch",
              {in_ready, reg_start, mem_start}, 0);
        @(negedge clk);
        if (t == 0 || t > 5) begin
            // R3
            check(!reg_start && !mem_start && !irq && !out_valid && in_ready, "R3",
                  "undefined test dropped",
                  {reg_start, mem_start, irq, out_valid, in_ready}, 5'b00001);
            return;
        end
        if (t == 1) begin
            // R4
            check(irq && out_valid && !reg_start && !mem_start, "R4", "irq with answer",
                  {irq, out_valid, reg_start, mem_start}, 4'b1100);
            @(negedge clk);
            check(!irq, "R4", "irq single cycle", irq, 0);
            receive(exp_answer(t, f, 1'b0, err, rd, ad));
            return;
        end
        // R2
        check(reg_start == (t <= 3) && mem_start == (t >= 4), "R2", "start pulse",
              {reg_start, mem_start}, {t <= 3, t >= 4});
        // R5
        check(test_id == 3'(t), "R5", "test_id", test_id, t);
        check(arg_module == f[15:8], "R5", "arg_module", arg_module, f[15:8]);
        check(arg_pattern == exp_pattern(t, f), "R5", "arg_pattern",
              arg_pattern, exp_pattern(t, f));
        @(negedge clk);
        check(!reg_start && !mem_start, "R2", "start lasts one cycle",
              {reg_start, mem_start}, 0);
        // R9: bytes offered while busy are not taken
        in_valid = 1'b1;
        in_data  = 8'hA5;
        for (int k = 0; k < 2; k++) begin
            check(!in_ready, "R9", "input closed in test", in_ready, 0);
            @(negedge clk);
        end
        in_valid = 1'b0;
        if (wrong_done) begin
            if (t <= 3) mem_done = 1'b1; else reg_done = 1'b1;
            res_err = 3'd7; res_rdata = 16'hDEAD; res_addr = 16'hBEEF;
            @(negedge clk);
            mem_done = 1'b0; reg_done = 1'b0;
            res_err = '0; res_rdata = '0; res_addr = '0;
            // R8
            check(!out_valid, "R8", "foreign done ignored", out_valid, 0);
        end
        repeat ($urandom % 4) @(negedge clk);
        check(arg_pattern == exp_pattern(t, f), "R5", "pattern held", arg_pattern,
              exp_pattern(t, f));
        if (t <= 3) reg_done = 1'b1; else mem_done = 1'b1;
        res_err = err; res_rdata = rd; res_addr = ad;
        @(negedge clk);
        reg_done = 1'b0; mem_done = 1'b0;
        res_err = '0; res_rdata = '0; res_addr = '0;
        check(out_valid, "R6/R7", "answer valid after done", out_valid, 1);
        receive(exp_answer(t, f, 1'b1, err, rd, ad));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1
        check(in_ready && !out_valid && !reg_start && !mem_start && !irq, "R1",
              "reset state", {in_ready, out_valid, reg_start, mem_start, irq}, 5'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready, "R1", "ready after reset", in_ready, 1);

        // directed corner cases
        run_frame(48'h5A_44_33_22_11_F8, 3'd0, 16'h0, 16'h0, 1'b0); // R3 test 0
        run_frame(48'h00_04_03_02_01_06, 3'd0, 16'h0, 16'h0, 1'b0); // R3 test 6
        run_frame(48'hFF_EE_DD_CC_BB_AF, 3'd0, 16'h0, 16'h0, 1'b0); // R3 test 7
        run_frame(48'h66_55_44_33_22_09, 3'd5, 16'h1, 16'h2, 1'b0); // R4 test 1
        run_frame(48'h00_10_20_30_40_02, 3'd0, 16'h0, 16'h0, 1'b1); // R6 R8
        run_frame(48'h00_9A_78_56_34_03, 3'd1, 16'h1234, 16'h03FF, 1'b0); // R7 left parity
        run_frame(48'h00_01_CD_AB_07_04, 3'd2, 16'hA5A5, 16'h0100, 1'b1); // R7 R8
        run_frame(48'h00_9A_78_56_03_FD, 3'd4, 16'h5AA5, 16'hFFFE, 1'b0); // R7 data
        run_frame(48'h00_9A_78_56_03_05, 3'd0, 16'h0, 16'h0, 1'b0); // R5 test 5
        run_frame(48'h00_11_22_33_44_03, 3'd7, 16'hFFFF, 16'h0000, 1'b0); // R7 all bits

        // constrained random frames
        for (int n = 0; n < 60; n++) begin
            logic [47:0] f;
            logic [2:0]  err;
            f = {$urandom, $urandom};
            f[2:0] = 3'($urandom % 8);
            err = ($urandom % 2) ? 3'($urandom) : 3'd0;
            run_frame(f, err, 16'($urandom), 16'($urandom), ($urandom % 4) == 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule